// File: doc/BRIEF.md
# Scatter-Gather List DMA Channel

This block is one DMA channel that walks a linked-by-position list of 8-byte descriptors held in host memory. Software places the list at some address and pulses `start` with that address. The channel reads each entry through a shared 32-bit memory port. It checks the entry, then moves the buffer the entry names, one 32-bit word at a time. The channel advances by 8 bytes per entry and stops after the entry that carries the last flag, where it emits a one-cycle `done`.

The direction is chosen per run by `rx_mode`, sampled at start. In transmit mode the channel reads the buffer from memory and offers the words on an outbound valid/ready stream. In receive mode it accepts words from an inbound valid/ready stream and writes them to memory. A receive run is gated by `rx_enable` for its whole life. A malformed entry parks the channel in a fault state until the next accepted start.

The list walker is a state machine with the states IDLE, HDR (fetch first word), BUF (fetch second word), CHECK (decode and decide), MOVE (word mover running), STEP (advance or finish) and FAULT. Its transitions are as follows:
- IDLE or FAULT go to HDR on an accepted start.
- HDR goes to BUF, and BUF goes to CHECK, each on a memory acknowledge.
- CHECK goes to FAULT on a bad entry, to IDLE when a receive run has lost its enable, to MOVE when there is data to move, and otherwise to STEP.
- MOVE goes to STEP when the mover finishes, or to IDLE when it aborts.
- STEP goes to IDLE with `done` after a last entry, and otherwise to HDR.

The word mover has the states IDLE, GET (obtain a word from memory or the inbound stream) and PUT (deliver it to the outbound stream or memory). Its transitions are as follows:
- IDLE goes to GET on launch.
- GET goes to PUT once a word is held.
- PUT goes back to GET while words remain.
- PUT goes to IDLE after the final word or on an abort.
- In receive mode, GET also goes to IDLE when the enable is lost.

Top module: `sgd_channel`

## Requirements
- R1: After reset `busy`, `done`, `err`, `mem_req`, `dev_out_valid` and `dev_in_ready` are all low, and they stay low while the channel is idle.
- R2: An entry at address P is read as word P (flags in bits 0 valid, 1 last, 5 transfer; bits 15:8 reserved; bits 31:16 length in bytes) then word P+4 (buffer address), and the next entry sits at P+8.
- R3: In transmit mode an entry with transfer set moves length/4 words read from ascending buffer addresses onto `dev_out_data` in order, and `dev_out_valid` with stable data is held until `dev_out_ready`.
- R4: In receive mode an entry with transfer set takes exactly length/4 words from the inbound stream and writes them to ascending buffer addresses, touching no word past the buffer end.
- R5: An entry with transfer clear, or with length 0, moves no data and the walk continues with the next entry.
- R6: After the entry with the last flag completes, `done` is high for exactly one cycle and `busy` falls.
- R7: A fetched entry with valid clear stops the walk with `err` high, `busy` low and no `done`; `err` stays high until the next accepted start, which clears it.
- R8: An entry whose length is not a multiple of 4 is treated as a fault in the same way as R7.
- R9: A start pulse while `busy` is high is ignored; the run in progress is unchanged.
- R10: A start with `rx_mode` high while `rx_enable` is low is ignored.
- R11: Dropping `rx_enable` during a receive run ends it after the word in flight, with no `done` and no further memory writes.
- R12: A memory request holds `mem_addr` and `mem_we` stable until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse, sampled when not busy |
| list_addr | input | ADDR_W | Address of the first descriptor |
| rx_mode | input | 1 | 1 = receive run, 0 = transmit run |
| rx_enable | input | 1 | Receive run enable |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Memory byte address (word aligned) |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access complete; read data valid |
| mem_rdata | input | 32 | Read data |
| dev_out_valid | output | 1 | Outbound word valid |
| dev_out_data | output | 32 | Outbound word |
| dev_out_ready | input | 1 | Device accepts outbound word |
| dev_in_valid | input | 1 | Inbound word valid |
| dev_in_data | input | 32 | Inbound word |
| dev_in_ready | output | 1 | Channel accepts inbound word |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle list completion pulse |
| err | output | 1 | Channel halted on a bad entry |

## Verification
A wrong walker state shows up within one entry. A bad pointer step fetches the wrong words and sends the wrong data or reports a fault. A missed last flag keeps `busy` high. A wrong fault decision raises `err` on a good list or lets a bad entry move data. A wrong mover count shows up at the stream within a word or two. It either delivers too many or too few words, or it writes past a buffer end, which guard words around each receive buffer catch. An abort or gating error is seen as a `done` pulse that should not appear, or as a memory write after the enable has fallen.

// File: rtl/sgd_pkg.sv
package sgd_pkg;
    // Descriptor format: fixed by the list layout in memory
    localparam int WORD_W      = 32;
    localparam int LEN_W       = 16;
    localparam int ENTRY_BYTES = 8;
    localparam int WORD_BYTES  = WORD_W / 8;
    localparam int BIT_VALID   = 0;
    localparam int BIT_LAST    = 1;
    localparam int BIT_XFER    = 5;

    typedef struct packed {
        logic             valid;
        logic             last;
        logic             xfer;
        logic [LEN_W-1:0] len;
        logic [WORD_W-1:0] buf_addr;
    } sgd_entry_t;

    typedef enum logic [2:0] {
        W_IDLE, W_HDR, W_BUF, W_CHECK, W_MOVE, W_STEP, W_FAULT
    } walk_state_t;

    typedef enum logic [1:0] {
        M_IDLE, M_GET, M_PUT
    } move_state_t;
endpackage

// File: rtl/sgd_entry_unpack.sv
module sgd_entry_unpack
    import sgd_pkg::*;
(
    input  logic [WORD_W-1:0] hdr_word,
    input  logic [WORD_W-1:0] buf_word,
    output sgd_entry_t        ent,
    output logic              bad
);
    // reserved and unassigned flag bits carry no meaning here
    logic unused_hdr_bits;
    assign unused_hdr_bits = ^{hdr_word[15:6], hdr_word[4:2]};

    always_comb begin
        ent.valid    = hdr_word[BIT_VALID];
        ent.last     = hdr_word[BIT_LAST];
        ent.xfer     = hdr_word[BIT_XFER];
        ent.len      = hdr_word[WORD_W-1 -: LEN_W];
        ent.buf_addr = buf_word;
        bad          = !ent.valid || (ent.len[1:0] != 2'b00);
    end
endmodule

// File: rtl/sgd_word_mover.sv
module sgd_word_mover
    import sgd_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              rx,
    input  logic              stop,
    input  logic [ADDR_W-1:0] base,
    input  logic [CNT_W-1:0]  words,
    output logic              req,
    output logic              we,
    output logic [ADDR_W-1:0] addr,
    output logic [WORD_W-1:0] word,
    input  logic              ack,
    input  logic [WORD_W-1:0] rdata,
    output logic              out_valid,
    input  logic              out_ready,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_data,
    output logic              in_ready,
    output logic              fin,
    output logic              aborted
);
    move_state_t       state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  left_q;
    logic [WORD_W-1:0] word_q;
    logic              rx_q;
    logic              got, put;

    assign got = rx_q ? (in_valid && !stop) : ack;
    assign put = rx_q ? ack : out_ready;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= M_IDLE;
        else        state_q <= state_d;
    end

    // next state and completion
    always_comb begin
        state_d = state_q;
        fin     = 1'b0;
        aborted = 1'b0;
        unique case (state_q)
            M_IDLE: if (go) state_d = M_GET;
            M_GET: begin
                if (rx_q && stop) begin
                    state_d = M_IDLE;
                    fin     = 1'b1;
                    aborted = 1'b1;
                end else if (got) begin
                    state_d = M_PUT;
                end
            end
            M_PUT: begin
                if (put) begin
                    if (left_q == CNT_W'(1)) begin
                        state_d = M_IDLE;
                        fin     = 1'b1;
                    end else if (stop) begin
                        state_d = M_IDLE;
                        fin     = 1'b1;
                        aborted = 1'b1;
                    end else begin
                        state_d = M_GET;
                    end
                end
            end
            default: state_d = M_IDLE;
        endcase
    end

    // datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            left_q <= '0;
            word_q <= '0;
            rx_q   <= 1'b0;
        end else begin
            if (state_q == M_IDLE && go) begin
                addr_q <= base;
                left_q <= words;
                rx_q   <= rx;
            end
            if (state_q == M_GET && got)
                word_q <= rx_q ? in_data : rdata;
            if (state_q == M_PUT && put) begin
                addr_q <= addr_q + ADDR_W'(WORD_BYTES);
                left_q <= left_q - CNT_W'(1);
            end
        end
    end

    // outputs
    always_comb begin
        req       = (state_q == M_GET && !rx_q) || (state_q == M_PUT && rx_q);
        we        = (state_q == M_PUT && rx_q);
        out_valid = (state_q == M_PUT && !rx_q);
        in_ready  = (state_q == M_GET && rx_q && !stop);
        addr      = addr_q;
        word      = word_q;
    end
endmodule

// File: rtl/sgd_channel.sv
module sgd_channel
    import sgd_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] list_addr,
    input  logic              rx_mode,
    input  logic              rx_enable,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ack,
    input  logic [31:0]       mem_rdata,
    output logic              dev_out_valid,
    output logic [31:0]       dev_out_data,
    input  logic              dev_out_ready,
    input  logic              dev_in_valid,
    input  logic [31:0]       dev_in_data,
    output logic              dev_in_ready,
    output logic              busy,
    output logic              done,
    output logic              err
);
    localparam int CNT_W = LEN_W - 2;

    walk_state_t       state_q, state_d;
    logic [ADDR_W-1:0] ptr_q;
    logic [WORD_W-1:0] hdr_q, buf_q;
    logic              mode_q, done_q;
    sgd_entry_t        ent;
    logic              bad, stop, accept, has_data;
    logic              mv_go, mv_req, mv_we, mv_fin, mv_abort;
    logic [ADDR_W-1:0] mv_addr;
    logic [WORD_W-1:0] mv_word;
    logic [CNT_W-1:0]  n_words;

    sgd_entry_unpack u_unpack (
        .hdr_word (hdr_q),
        .buf_word (buf_q),
        .ent      (ent),
        .bad      (bad)
    );

    assign stop     = mode_q && !rx_enable;
    assign accept   = start && (!rx_mode || rx_enable);
    assign n_words  = ent.len[LEN_W-1:2];
    assign has_data = ent.xfer && (n_words != '0);
    assign mv_go    = (state_q == W_CHECK) && !bad && !stop && has_data;

    sgd_word_mover #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_mover (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (mv_go),
        .rx        (mode_q),
        .stop      (stop),
        .base      (ADDR_W'(ent.buf_addr)),
        .words     (n_words),
        .req       (mv_req),
        .we        (mv_we),
        .addr      (mv_addr),
        .word      (mv_word),
        .ack       (mem_ack),
        .rdata     (mem_rdata),
        .out_valid (dev_out_valid),
        .out_ready (dev_out_ready),
        .in_valid  (dev_in_valid),
        .in_data   (dev_in_data),
        .in_ready  (dev_in_ready),
        .fin       (mv_fin),
        .aborted   (mv_abort)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= W_IDLE;
        else        state_q <= state_d;
    end

    // list walk transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            W_IDLE, W_FAULT: if (accept) state_d = W_HDR;
            W_HDR:   if (mem_ack) state_d = W_BUF;
            W_BUF:   if (mem_ack) state_d = W_CHECK;
            W_CHECK: begin
                if (bad)           state_d = W_FAULT;
                else if (stop)     state_d = W_IDLE;
                else if (has_data) state_d = W_MOVE;
                else               state_d = W_STEP;
            end
            W_MOVE:  if (mv_fin) state_d = mv_abort ? W_IDLE : W_STEP;
            W_STEP:  state_d = ent.last ? W_IDLE : W_HDR;
            default: state_d = W_IDLE;
        endcase
    end

    // walker datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q  <= '0;
            hdr_q  <= '0;
            buf_q  <= '0;
            mode_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= (state_q == W_STEP) && ent.last;
            if ((state_q == W_IDLE || state_q == W_FAULT) && accept) begin
                ptr_q  <= list_addr;
                mode_q <= rx_mode;
            end
            if (state_q == W_HDR && mem_ack) hdr_q <= mem_rdata;
            if (state_q == W_BUF && mem_ack) buf_q <= mem_rdata;
            if (state_q == W_STEP && !ent.last)
                ptr_q <= ptr_q + ADDR_W'(ENTRY_BYTES);
        end
    end

    // outputs
    always_comb begin
        busy         = !(state_q == W_IDLE || state_q == W_FAULT);
        err          = (state_q == W_FAULT);
        done         = done_q;
        mem_req      = (state_q == W_HDR) || (state_q == W_BUF) || mv_req;
        mem_we       = mv_we;
        mem_wdata    = mv_word;
        dev_out_data = mv_word;
        unique case (state_q)
            W_HDR:   mem_addr = ptr_q;
            W_BUF:   mem_addr = ptr_q + ADDR_W'(WORD_BYTES);
            default: mem_addr = mv_addr;
        endcase
    end
endmodule

// File: rtl/sgd_channel_chk.sv
module sgd_channel_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [ADDR_W-1:0] list_addr,
    input logic              rx_mode,
    input logic              rx_enable,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [31:0]       mem_wdata,
    input logic              mem_ack,
    input logic [31:0]       mem_rdata,
    input logic              dev_out_valid,
    input logic [31:0]       dev_out_data,
    input logic              dev_out_ready,
    input logic              dev_in_valid,
    input logic [31:0]       dev_in_data,
    input logic              dev_in_ready,
    input logic              busy,
    input logic              done,
    input logic              err
);
    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_req && !dev_out_valid && !dev_in_ready));

    // R3
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_out_valid && !dev_out_ready) |=> (dev_out_valid && $stable(dev_out_data)));

    // R4
    dir_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(dev_out_valid && dev_in_ready));

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6
    done_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!err && !busy));

    // R7
    fault_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!busy && !mem_req));

    // R12
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
endmodule

bind sgd_channel sgd_channel_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sgd_channel_tb.sv
module sgd_channel_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] list_addr = '0;
    logic        rx_mode = 1'b0;
    logic        rx_enable = 1'b1;
    logic        mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        dev_out_valid, dev_out_ready, dev_in_valid, dev_in_ready;
    logic [31:0] dev_out_data, dev_in_data;
    logic        busy, done, err;

    int checks = 0;
    int errors = 0;

    logic [31:0] mem [0:255];
    logic [31:0] sink [0:63];
    int          sink_n = 0;
    logic [31:0] src_words [0:63];
    int          src_idx = 0;
    int          src_cnt = 0;
    int          done_cnt = 0;
    logic        bp_on = 1'b0;
    logic        tick = 1'b0;

    always #4 clk = ~clk;

    sgd_channel u_dut (.*);

    // memory model: one-cycle acknowledge
    always @(posedge clk) begin
        if (mem_req && !mem_ack) begin
            mem_ack   <= 1'b1;
            mem_rdata <= mem[mem_addr[9:2]];
            if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
        end else begin
            mem_ack <= 1'b0;
        end
    end
    initial begin mem_ack = 1'b0; mem_rdata = '0; end

    // stream models
    always @(posedge clk) begin
        tick <= ~tick;
        if (dev_out_valid && dev_out_ready) begin
            sink[sink_n[5:0]] <= dev_out_data;
            sink_n <= sink_n + 1;
        end
        if (dev_in_valid && dev_in_ready) src_idx <= src_idx + 1;
        if (done) done_cnt <= done_cnt + 1;
    end
    assign dev_out_ready = bp_on ? tick : 1'b1;
    assign dev_in_valid  = (src_idx < src_cnt);
    assign dev_in_data   = src_words[src_idx[5:0]];

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic put_entry(input int a, input logic [7:0] flags, input logic [15:0] len, input logic [31:0] b);
        mem[a >> 2]       = {len, 8'h00, flags};
        mem[(a >> 2) + 1] = b;
    endtask

    task automatic kick(input logic [31:0] a, input logic rx);
        @(negedge clk);
        list_addr = a; rx_mode = rx; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 3000 && busy; i++) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        // R1: quiet outputs during and after reset
        chk(!busy && !done && !err, "R1 status", {busy, done, err}, 0);
        chk(!mem_req && !dev_out_valid && !dev_in_ready, "R1 ports",
            {mem_req, dev_out_valid, dev_in_ready}, 0);
    endtask

    task automatic t_tx_chain();
        int s0 = sink_n; int d0 = done_cnt;
        put_entry('h000, 8'h21, 16'd8, 32'h100);
        put_entry('h008, 8'h23, 16'd4, 32'h200);
        put_entry('h0C0, 8'h23, 16'd4, 32'h280);
        mem['h100 >> 2] = 32'hA1A1_0001; mem['h104 >> 2] = 32'hA1A1_0002;
        mem['h200 >> 2] = 32'hB2B2_0003; mem['h280 >> 2] = 32'hEEEE_EEEE;
        bp_on = 1'b1;
        kick(32'h000, 1'b0);
        repeat (4) @(negedge clk);
        // R9: start while busy must be ignored
        list_addr = 32'h0C0; start = 1'b1; @(negedge clk); start = 1'b0;
        wait_idle();
        bp_on = 1'b0;
        chk(sink_n - s0 == 3, "R9 word count", sink_n - s0, 3);
        chk(sink[s0[5:0]] == 32'hA1A1_0001, "R3 word0", sink[s0[5:0]], 32'hA1A1_0001);
        chk(sink[(s0 + 1) % 64] == 32'hA1A1_0002, "R3 word1", sink[(s0 + 1) % 64], 32'hA1A1_0002);
        chk(sink[(s0 + 2) % 64] == 32'hB2B2_0003, "R2 second entry", sink[(s0 + 2) % 64], 32'hB2B2_0003);
        chk(done_cnt - d0 == 1 && !err, "R6 single done", done_cnt - d0, 1);
    endtask

    task automatic t_rx_basic();
        int d0 = done_cnt;
        put_entry('h020, 8'h23, 16'd12, 32'h300);
        for (int i = 0; i < 4; i++) mem[('h300 >> 2) + i] = 32'hDEAD_0000;
        for (int i = 0; i < 3; i++) src_words[(src_idx + i) % 64] = 32'hC0DE_0010 + i;
        src_cnt = src_idx + 3;
        kick(32'h020, 1'b1);
        wait_idle();
        for (int i = 0; i < 3; i++)
            chk(mem[('h300 >> 2) + i] == 32'hC0DE_0010 + i, "R4 written word",
                mem[('h300 >> 2) + i], 32'hC0DE_0010 + i);
        chk(mem['h30C >> 2] == 32'hDEAD_0000, "R4 buffer end", mem['h30C >> 2], 32'hDEAD_0000);
        chk(done_cnt - d0 == 1, "R6 rx done", done_cnt - d0, 1);
    endtask

    task automatic t_skip();
        int s0 = sink_n; int d0 = done_cnt;
        put_entry('h060, 8'h01, 16'd8, 32'h180);
        put_entry('h068, 8'h21, 16'd0, 32'h190);
        put_entry('h070, 8'h23, 16'd4, 32'h1A0);
        mem['h1A0 >> 2] = 32'h5EED_0007;
        kick(32'h060, 1'b0);
        wait_idle();
        // R5: only the third entry moves data
        chk(sink_n - s0 == 1, "R5 skip count", sink_n - s0, 1);
        chk(sink[s0[5:0]] == 32'h5EED_0007, "R5 data", sink[s0[5:0]], 32'h5EED_0007);
        chk(done_cnt - d0 == 1, "R5 done", done_cnt - d0, 1);
    endtask

    task automatic t_invalid();
        int s0 = sink_n; int d0 = done_cnt;
        put_entry('h090, 8'h21, 16'd4, 32'h100);
        put_entry('h098, 8'h22, 16'd4, 32'h100);
        kick(32'h090, 1'b0);
        wait_idle();
        chk(err && !busy, "R7 fault state", {err, busy}, 2'b10);
        chk(done_cnt == d0, "R7 no done", done_cnt - d0, 0);
        chk(sink_n - s0 == 1, "R7 first entry moved", sink_n - s0, 1);
    endtask

    task automatic t_misalign();
        int d0 = done_cnt;
        put_entry('h0A0, 8'h23, 16'd6, 32'h100);
        kick(32'h0A0, 1'b0);
        wait_idle();
        chk(err && done_cnt == d0, "R8 length fault", {err}, 1);
        // R7: accepted start clears err
        put_entry('h0B0, 8'h03, 16'd0, 32'h0);
        kick(32'h0B0, 1'b0);
        chk(!err, "R7 err cleared", err, 0);
        wait_idle();
        chk(!err && done_cnt - d0 == 1, "R7 restart done", done_cnt - d0, 1);
    endtask

    task automatic t_rx_gate();
        int d0 = done_cnt;
        rx_enable = 1'b0;
        kick(32'h020, 1'b1);
        chk(!busy && !mem_req, "R10 gated start", {busy, mem_req}, 0);
        repeat (3) @(negedge clk);
        chk(!busy && done_cnt == d0, "R10 stays idle", busy, 0);
        rx_enable = 1'b1;
    endtask

    task automatic t_rx_abort();
        int d0 = done_cnt;
        put_entry('h0D0, 8'h23, 16'd16, 32'h340);
        for (int i = 0; i < 4; i++) mem[('h340 >> 2) + i] = 32'hDEAD_0001;
        src_words[src_idx % 64] = 32'hF00D_0000;
        src_words[(src_idx + 1) % 64] = 32'hF00D_0001;
        src_cnt = src_idx + 2;
        kick(32'h0D0, 1'b1);
        for (int i = 0; i < 200 && mem['h344 >> 2] != 32'hF00D_0001; i++) @(negedge clk);
        @(negedge clk);
        rx_enable = 1'b0;
        repeat (3) @(negedge clk);
        chk(!busy, "R11 abort ends run", busy, 0);
        chk(done_cnt == d0, "R11 no done", done_cnt - d0, 0);
        chk(mem['h340 >> 2] == 32'hF00D_0000, "R11 word kept", mem['h340 >> 2], 32'hF00D_0000);
        chk(mem['h348 >> 2] == 32'hDEAD_0001, "R11 no extra write", mem['h348 >> 2], 32'hDEAD_0001);
        rx_enable = 1'b1;
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = '0;
        for (int i = 0; i < 64; i++) begin sink[i] = '0; src_words[i] = '0; end
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_reset();
        t_tx_chain();
        t_rx_basic();
        t_skip();
        t_invalid();
        t_misalign();
        t_rx_gate();
        t_rx_abort();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog R6 actual=busy expected=idle");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule